// File: doc/BRIEF.md
# Word-Fed Two-Wire Bus Master

This block is a two-wire serial bus master, I2C-like, that takes its commands from a 32-bit transmit FIFO. Each command starts with a header word. The low byte of the header is the address byte sent on the wire: the target address in bits 7:1 and the direction in bit 0. Bits 15:8 give the number of data bytes in the message. Bits 23:16 and 31:24 carry the first two data bytes of a write. Further write bytes are taken from the words that follow the header, four to a word. The master issues START, sends the address byte and checks the target's ACK. It then either shifts the write bytes out, checking an ACK after each one, or clocks in read bytes and pushes each one to a receive FIFO. It ends the message with a STOP. SCL runs without a break from START to STOP.

Software drives an enable input. While enable is low, no new header is taken. A message that is already under way runs to its end. The idle output tells software when the machine has come to rest, so it can preload the FIFO before enabling the block again. Two sticky status bits are cleared only by reset. One records a target that failed to acknowledge. The other records a write whose next data word was not in the FIFO when it was needed.

The open-drain pins are modelled as drive-low enables (`scl_oe_o`, `sda_oe_o`) plus the sensed line levels (`scl_i`, `sda_i`). Each bit takes four phases of `QDIV` system clocks. SCL is low in phases 0 and 3 and high in phases 1 and 2.

Top module: `cmdq_i2c_master`

## Requirements
- R1: After START, the first byte sent is header bits 7:0, MSB first: address in bits 7:1, and bit 0 = 1 for a read, 0 for a write. Header bits 15:8 give the data byte count.
- R2: A write sends exactly the number of bytes in the count, each MSB first. They come in this order: header bits 23:16, then 31:24, then each following word from bits 7:0 up to bits 31:24.
- R3: The master releases SDA in every ACK slot of the address byte and of each write byte. A high SDA in that slot (NAK) aborts the message with STOP and sets `nak_err_o`, which is sticky. The message's remaining words that are already queued in the FIFO are popped and discarded.
- R4: On a read, the master releases SDA during the data bits and samples SDA while SCL is high. It drives ACK (low) after each byte except the last, and releases SDA (NAK) after the last. It pulses `rx_push_o` once per byte with the byte on `rx_data_o`.
- R5: A read takes only its header word from the FIFO.
- R6: If a write needs its next byte and both the header and the FIFO are used up, the master sets sticky `underflow_o`, issues STOP and returns to idle.
- R7: A header is popped only while `enable_i` is high. Lowering `enable_i` lets the current message finish. `idle_o` is high exactly while the master is at rest between messages.
- R8: Every SCL high period inside a message lasts 2*QDIV clocks. SCL keeps toggling from START to STOP.
- R9: `tx_pop_o` is asserted only when `tx_valid_i` is high. While idle, both drive-low enables are off.
- R10: A header with a byte count of 0 is popped and dropped, with no bus activity.
- R11: While the master has released SCL but `scl_i` reads low, the bit phase does not advance (clock stretching).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Allows new headers to be taken |
| tx_data_i | input | 32 | Head word of the transmit FIFO |
| tx_valid_i | input | 1 | Transmit FIFO not empty |
| tx_pop_o | output | 1 | Pops the head word of the transmit FIFO |
| rx_data_o | output | 8 | Received read byte |
| rx_push_o | output | 1 | Pushes `rx_data_o` into the receive FIFO |
| idle_o | output | 1 | Master at rest between messages |
| underflow_o | output | 1 | Sticky write-data underflow |
| nak_err_o | output | 1 | Sticky missing-ACK error |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | Drives SCL low when high |
| sda_oe_o | output | 1 | Drives SDA low when high |

## Verification
The bench targets the word boundary between the header's two data bytes and the next FIFO word. A design with the byte lanes swapped, or one that pops too early, puts the bytes on the wire out of order. It also aims a NAK at the second data byte of a three-word message. If the flush count is off, a discarded data word is read as the next header, or a real header is thrown away, and the following message comes out wrong. Other cases covered are:
- a read whose final acknowledge must be a NAK;
- a disable issued in mid-message, followed by a zero-length header;
- a write started with an empty FIFO, which must flag underflow instead of sending stale bytes;
- SCL held low by the target, which must freeze the START.

// File: rtl/cmdq_i2c_pkg.sv
package cmdq_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_STOP,
    ST_FLUSH
  } mst_state_e;
endpackage

// File: rtl/cmdq_i2c_tick.sv
module cmdq_i2c_tick #(
  parameter int unsigned QDIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(QDIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmdq_i2c_feed.sv
// Holds the unsent bytes of the current word, low byte first.
module cmdq_i2c_feed
  import cmdq_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_load_i,
  input  logic [15:0]       hdr_hi_i,
  input  logic              take_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              have_o,
  output logic              pop_o,
  output logic [1:0]        avail_o
);
  logic [23:0] word_q;
  logic [1:0]  avail_q;

  assign byte_o  = (avail_q != 2'd0) ? word_q[7:0] : tx_data_i[7:0];
  assign have_o  = (avail_q != 2'd0) || tx_valid_i;
  assign pop_o   = take_i && (avail_q == 2'd0) && tx_valid_i;
  assign avail_o = avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      avail_q <= '0;
    end else if (hdr_load_i) begin
      word_q  <= {8'h00, hdr_hi_i};
      avail_q <= 2'd2;
    end else if (take_i) begin
      if (avail_q != 2'd0) begin
        word_q  <= word_q >> 8;
        avail_q <= avail_q - 2'd1;
      end else if (tx_valid_i) begin
        word_q  <= tx_data_i[31:8];
        avail_q <= 2'd3;
      end
    end
  end
endmodule

// File: rtl/cmdq_i2c_master.sv
module cmdq_i2c_master
  import cmdq_i2c_pkg::*;
#(
  parameter int unsigned QDIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_pop_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              idle_o,
  output logic              underflow_o,
  output logic              nak_err_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  mst_state_e        st_q;
  logic [1:0]        ph_q;
  logic [3:0]        bcnt_q;
  logic [BYTE_W-1:0] sh_q, rxd_q;
  logic [LEN_W-1:0]  rem_q, fl_q, fl_calc;
  logic              rd_q, addr_q, ack_q, nak_q, unf_q, rxp_q;

  logic              tick, run, scl_hi, sda_lo, hdr_take, take, have;
  logic              feed_pop, flush_pop, frame_end, rd_data;
  logic [BYTE_W-1:0] feed_byte;
  logic [1:0]        avail;
  logic [LEN_W:0]    fl_diff;

  assign rd_data = rd_q && !addr_q;

  always_comb begin
    scl_hi = 1'b1;
    sda_lo = 1'b0;
    unique case (st_q)
      ST_START: begin scl_hi = (ph_q != 2'd3); sda_lo = (ph_q != 2'd0); end
      ST_BIT: begin
        scl_hi = (ph_q == 2'd1) || (ph_q == 2'd2);
        if (bcnt_q < 4'd8) sda_lo = !rd_data && !sh_q[7];
        else               sda_lo = rd_data && (rem_q > 8'd1);  // ACK all but last
      end
      ST_STOP: begin scl_hi = (ph_q != 2'd0); sda_lo = (ph_q < 2'd2); end
      default: ;
    endcase
  end

  assign scl_oe_o  = !scl_hi;
  assign sda_oe_o  = sda_lo;
  // released SCL held low by the target freezes the phase
  assign run       = (st_q == ST_START || st_q == ST_BIT || st_q == ST_STOP) && !(scl_hi && !scl_i);
  assign hdr_take  = (st_q == ST_IDLE) && enable_i && tx_valid_i;
  assign frame_end = (st_q == ST_BIT) && tick && (ph_q == 2'd3) && (bcnt_q == 4'd8);
  assign take      = frame_end && !rd_q && ack_q && (rem_q != '0) && have;
  assign flush_pop = (st_q == ST_FLUSH) && (fl_q != '0) && tx_valid_i;
  assign tx_pop_o  = hdr_take || feed_pop || flush_pop;

  // queued words still owed to the aborted message
  assign fl_diff = {1'b0, rem_q} + 9'd3 - {7'd0, avail};
  assign fl_calc = (rem_q > {6'd0, avail}) ? LEN_W'(fl_diff >> 2) : '0;

  cmdq_i2c_tick #(.QDIV(QDIV)) i_tick (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick)
  );

  cmdq_i2c_feed i_feed (
    .clk_i, .rst_ni,
    .hdr_load_i(hdr_take), .hdr_hi_i(tx_data_i[31:16]),
    .take_i(take), .tx_data_i, .tx_valid_i,
    .byte_o(feed_byte), .have_o(have), .pop_o(feed_pop), .avail_o(avail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= '0; bcnt_q <= '0; sh_q <= '0; rxd_q <= '0;
      rem_q <= '0; fl_q <= '0; rd_q <= 1'b0; addr_q <= 1'b0; ack_q <= 1'b0;
      nak_q <= 1'b0; unf_q <= 1'b0; rxp_q <= 1'b0;
    end else begin
      rxp_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (hdr_take) begin
          rd_q   <= tx_data_i[0];
          sh_q   <= tx_data_i[7:0];
          rem_q  <= tx_data_i[15:8];
          addr_q <= 1'b1;
          ph_q   <= '0;
          bcnt_q <= '0;
          if (tx_data_i[15:8] != '0) st_q <= ST_START;
        end
        ST_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) st_q <= ST_BIT;
        end
        ST_BIT: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd2) begin
            if (bcnt_q < 4'd8) begin
              if (rd_data) sh_q <= {sh_q[6:0], sda_i};
            end else ack_q <= !sda_i;
          end
          if (ph_q == 2'd3) begin
            if (bcnt_q < 4'd8) begin
              bcnt_q <= bcnt_q + 4'd1;
              if (!rd_data) sh_q <= sh_q << 1;
            end else begin
              bcnt_q <= '0;
              addr_q <= 1'b0;
              if (rd_data) begin
                rxd_q <= sh_q;
                rxp_q <= 1'b1;
                rem_q <= rem_q - 8'd1;
                if (rem_q == 8'd1) st_q <= ST_STOP;
              end else if (!ack_q) begin
                nak_q <= 1'b1;
                fl_q  <= rd_q ? '0 : fl_calc;
                st_q  <= ST_STOP;
              end else if (rd_q) begin
                st_q <= ST_BIT;
              end else if (rem_q == '0) begin
                st_q <= ST_STOP;
              end else if (have) begin
                sh_q  <= feed_byte;
                rem_q <= rem_q - 8'd1;
              end else begin
                unf_q <= 1'b1;
                st_q  <= ST_STOP;
              end
            end
          end
        end
        ST_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) st_q <= (fl_q != '0) ? ST_FLUSH : ST_IDLE;
        end
        ST_FLUSH: begin
          if (flush_pop) fl_q <= fl_q - 8'd1;
          else begin
            fl_q <= '0;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_data_o   = rxd_q;
  assign rx_push_o   = rxp_q;
  assign idle_o      = (st_q == ST_IDLE);
  assign underflow_o = unf_q;
  assign nak_err_o   = nak_q;
endmodule

// File: rtl/cmdq_i2c_master_chk.sv
module cmdq_i2c_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic tx_valid_i,
  input logic tx_pop_o,
  input logic rx_push_o,
  input logic idle_o,
  input logic underflow_o,
  input logic nak_err_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);
  a_r9_pop_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i);

  a_r7_idle_pop_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && tx_pop_o) |-> enable_i);

  a_r9_idle_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!scl_oe_o && !sda_oe_o));

  a_r3_nak_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_err_o |=> nak_err_o);

  a_r6_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  a_r6_underflow_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> !idle_o);

  a_r4_push_in_message: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !idle_o);
endmodule

bind cmdq_i2c_master cmdq_i2c_master_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .tx_valid_i(tx_valid_i),
  .tx_pop_o(tx_pop_o), .rx_push_o(rx_push_o), .idle_o(idle_o),
  .underflow_o(underflow_o), .nak_err_o(nak_err_o),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/test_cmdq_i2c_master.sv
module test_cmdq_i2c_master;
  localparam int QDIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable = 1'b0;
  always #4 clk = ~clk;

  // transmit FIFO model
  logic [31:0] fmem [64];
  int wr = 0, rd = 0;
  logic        tx_valid, tx_pop;
  logic [31:0] tx_data;
  assign tx_valid = (wr != rd);
  assign tx_data  = fmem[rd[5:0]];
  always @(posedge clk) if (tx_pop) rd <= rd + 1;

  // bus
  logic sl_low = 1'b0, tb_scl_low = 1'b0;
  logic scl_oe, sda_oe, scl, sda;
  assign scl = !(scl_oe || tb_scl_low);
  assign sda = !(sda_oe || sl_low);

  logic [7:0] rx_data;
  logic rx_push, idle, unf, nak;

  cmdq_i2c_master #(.QDIV(QDIV)) i_cmdq_i2c_master (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_push_o(rx_push), .idle_o(idle),
    .underflow_o(unf), .nak_err_o(nak),
    .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] rdb(int i);
    return 8'h3C + 8'(i * 37);
  endfunction
  function automatic logic bitof(int i, int b);
    logic [7:0] v;
    v = rdb(i);
    return v[b];
  endfunction
  function automatic logic [31:0] hdr(logic [6:0] a, logic r, logic [7:0] n, logic [7:0] b0, logic [7:0] b1);
    return {b1, b0, n, a, r};
  endfunction

  // target model
  logic p_scl = 1'b1, p_sda = 1'b1, act = 1'b0, aph = 1'b0, txm = 1'b0, m_ack = 1'b0, sack = 1'b0;
  logic [7:0] ssh = '0;
  int bc = 0, rdi = 0, n_rx = 0, n_mack = 0, n_start = 0, nak_at = -1;
  logic [7:0] rxlog [64];
  logic mack_log [64];

  always @(posedge clk) begin
    p_scl <= scl;
    p_sda <= sda;
    if (scl && p_scl && p_sda && !sda) begin
      act <= 1'b1; bc <= 0; aph <= 1'b1; txm <= 1'b0; sl_low <= 1'b0; n_start <= n_start + 1;
    end else if (scl && p_scl && !p_sda && sda) begin
      act <= 1'b0; txm <= 1'b0; sl_low <= 1'b0;
    end else if (act && scl && !p_scl) begin
      if (bc < 8) begin
        if (!txm) ssh <= {ssh[6:0], sda};
        bc <= bc + 1;
      end else begin
        if (txm) begin
          mack_log[n_mack[5:0]] <= !sda; n_mack <= n_mack + 1; m_ack <= !sda;
        end
        bc <= 9;
      end
    end else if (act && !scl && p_scl) begin
      if (bc == 8) begin
        if (!txm) begin
          rxlog[n_rx[5:0]] <= ssh; n_rx <= n_rx + 1;
          sl_low <= (n_rx != nak_at); sack <= (n_rx != nak_at);
        end else sl_low <= 1'b0;
      end else if (bc == 9) begin
        bc <= 0; aph <= 1'b0;
        if (aph && ssh[0] && sack) begin
          txm <= 1'b1; rdi <= 0; sl_low <= !bitof(0, 7);
        end else if (txm && m_ack) begin
          rdi <= rdi + 1; sl_low <= !bitof(rdi + 1, 7);
        end else begin
          txm <= 1'b0; sl_low <= 1'b0;
        end
      end else if (txm && bc >= 1 && bc <= 7) begin
        sl_low <= !bitof(rdi, 7 - bc);
      end
    end
  end

  // receive FIFO capture and SCL high-time monitor
  logic [7:0] mrx [64];
  int n_mrx = 0, hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    if (rx_push) begin mrx[n_mrx[5:0]] <= rx_data; n_mrx <= n_mrx + 1; end
    if (scl) hi_cnt <= hi_cnt + 1;
    else begin
      if (hi_cnt != 0) last_hi <= hi_cnt;
      hi_cnt <= 0;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk);
    fmem[wr[5:0]] = w;
    wr = wr + 1;
  endtask

  task automatic run_msg();
    int n = 0;
    while (idle && n < 400) begin @(negedge clk); n++; end
    while (!idle && n < 100000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 idle after reset", 32'(idle), 1);
    chk("R9 scl released", 32'(scl_oe), 0);
    chk("R9 sda released", 32'(sda_oe), 0);
    chk("R9 no pop", 32'(tx_pop), 0);
    chk("R3 nak clear", 32'(nak), 0);
    chk("R6 underflow clear", 32'(unf), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic t_write_long();
    int b0 = n_rx;
    push(hdr(7'h50, 1'b0, 8'd7, 8'h11, 8'h22));
    push(32'h6655_4433);
    push(32'h0000_0077);
    run_msg();
    chk("R1 address byte", 32'(rxlog[b0[5:0]]), 32'hA0);
    for (int i = 0; i < 7; i++)
      chk("R2 write byte order", 32'(rxlog[(b0 + 1 + i) % 64]), 32'h11 * (i + 1));
    chk("R2 byte count", 32'(n_rx - b0), 8);
    chk("R2 words consumed", 32'(wr - rd), 0);
    chk("R8 scl high time", 32'(last_hi), 2 * QDIV);
    chk("R3 no nak", 32'(nak), 0);
    chk("R9 idle bus free", 32'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_write_one();
    int b0 = n_rx;
    push(hdr(7'h12, 1'b0, 8'd1, 8'h5A, 8'hFF));
    run_msg();
    chk("R1 address byte short", 32'(rxlog[b0[5:0]]), 32'h24);
    chk("R2 single byte", 32'(rxlog[(b0 + 1) % 64]), 32'h5A);
    chk("R2 single count", 32'(n_rx - b0), 2);
  endtask

  task automatic t_read_disable();
    int b0 = n_rx, m0 = n_mrx, k0 = n_mack, s0;
    int n = 0;
    push(hdr(7'h2A, 1'b1, 8'd3, 8'h00, 8'h00));
    push(32'hDEAD_0000);
    while (idle && n < 400) begin @(negedge clk); n++; end
    enable = 1'b0;
    while (!idle && n < 100000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk("R1 read address byte", 32'(rxlog[b0[5:0]]), 32'h55);
    chk("R4 read count", 32'(n_mrx - m0), 3);
    for (int i = 0; i < 3; i++)
      chk("R4 read data", 32'(mrx[(m0 + i) % 64]), 32'(rdb(i)));
    chk("R4 ack first", 32'(mack_log[k0[5:0]]), 1);
    chk("R4 ack second", 32'(mack_log[(k0 + 1) % 64]), 1);
    chk("R4 nak last", 32'(mack_log[(k0 + 2) % 64]), 0);
    chk("R5 header only", 32'(wr - rd), 1);
    repeat (100) @(negedge clk);
    chk("R7 idle while disabled", 32'(idle), 1);
    chk("R7 no pop while disabled", 32'(wr - rd), 1);
    s0 = n_start;
    enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 zero length popped", 32'(wr - rd), 0);
    chk("R10 no bus activity", 32'(n_start - s0), 0);
    chk("R10 still idle", 32'(idle), 1);
  endtask

  task automatic t_nak_flush();
    int b0 = n_rx;
    nak_at = b0 + 2;
    push(hdr(7'h33, 1'b0, 8'd10, 8'hA1, 8'hA2));
    push(32'h0403_0201);
    push(32'h0807_0605);
    run_msg();
    chk("R3 nak sticky set", 32'(nak), 1);
    chk("R3 bytes before abort", 32'(n_rx - b0), 3);
    chk("R3 words flushed", 32'(wr - rd), 0);
    chk("R3 stop issued", 32'(act), 0);
    nak_at = -1;
    b0 = n_rx;
    push(hdr(7'h34, 1'b0, 8'd1, 8'hC3, 8'h00));
    run_msg();
    chk("R3 next header intact", 32'(rxlog[b0[5:0]]), 32'h68);
    chk("R3 next data intact", 32'(rxlog[(b0 + 1) % 64]), 32'hC3);
    chk("R3 nak stays set", 32'(nak), 1);
  endtask

  task automatic t_underflow();
    int b0 = n_rx;
    chk("R6 underflow clear before", 32'(unf), 0);
    push(hdr(7'h44, 1'b0, 8'd6, 8'hE1, 8'hE2));
    run_msg();
    chk("R6 underflow set", 32'(unf), 1);
    chk("R6 header bytes only", 32'(n_rx - b0), 3);
    chk("R6 last byte", 32'(rxlog[(b0 + 2) % 64]), 32'hE2);
    chk("R6 stop issued", 32'(act), 0);
    chk("R6 back to idle", 32'(idle), 1);
  endtask

  task automatic t_stretch();
    int b0 = n_rx, s0 = n_start;
    @(negedge clk);
    tb_scl_low = 1'b1;
    push(hdr(7'h21, 1'b0, 8'd1, 8'h99, 8'h00));
    repeat (100) @(negedge clk);
    chk("R11 start held", 32'(sda_oe), 0);
    chk("R11 scl left released", 32'(scl_oe), 0);
    chk("R11 no start seen", 32'(n_start - s0), 0);
    tb_scl_low = 1'b0;
    run_msg();
    chk("R11 message after release", 32'(rxlog[(b0 + 1) % 64]), 32'h99);
    chk("R11 address after release", 32'(rxlog[b0[5:0]]), 32'h42);
  endtask

  initial begin
    t_reset();
    t_write_long();
    t_write_one();
    t_read_disable();
    t_nak_flush();
    t_underflow();
    t_stretch();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule